// File: doc/BRIEF.md
# Bus Error Detect and Capture Unit

This block sits beside a bus interface and collects the error strobes that the protocol engine raises. Each error type owns one bit in a 32-bit detect register. The bit is set when its strobe fires, whether or not interrupts are enabled for it. Software clears detect bits by writing ones. A per-bit enable register selects which pending detect bits drive a level interrupt, and the interrupt leaves the block through one register stage.

For the first error after the detect register has been fully cleared, the block latches the error's address, attribute and data payloads, together with the vector of error types that fired with it. Later errors only add detect bits, so the snapshot always describes the earliest fault. A valid flag in the capture attribute register shows whether the snapshot is live.

The block also drives the read data returned for outbound reads. A configuration read that ends in a master abort returns all-ones. The master-abort detect bit still records the event, and clearing its enable bit keeps such expected aborts from raising the interrupt.

Top module: `bus_err_capture`

## Requirements
- R1: After reset, the detect, enable and capture registers read zero and `irq_o` is low.
- R2: A strobe on `err_ev_i[k]` sets detect bit k. The new value is readable at register select 0 after the next rising clock edge.
- R3: A write to register select 0 clears every detect bit whose write-data bit is 1 and leaves every other bit unchanged. A write never sets a detect bit.
- R4: If a strobe sets a bit in the same cycle that a write clears it, the bit ends up set.
- R5: Detect bits are recorded whether or not they are enabled. `irq_o` equals the OR over all bits of (detect AND enable), delayed by one clock. Enable is register select 1.
- R6: The first error seen while the detect register reads zero latches its address (select 3), data (select 4), attribute (bits 7:0 of select 2) and type vector (bits 21:16 of select 2). Later errors leave all of these unchanged.
- R7: Capture re-arms once every detect bit is zero. While the detect register is zero, the valid flag (bit 31 of select 2) reads 0. After a capture it reads 1.
- R8: Detect and enable bit positions 31:6 always read zero. Writes to selects 2, 3 and 4 have no effect.
- R9: When `ob_cfg_ma_i` is high, `ob_rdata_o` is all-ones. Otherwise it equals `ob_rdata_i`.
- R10: A master abort (bit 0) with its enable clear is recorded without raising `irq_o`. A parity error (bit 1) with its enable set raises `irq_o`.
- R11: Writing all-ones to select 0 clears every detect bit, and `irq_o` falls one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| err_ev_i | input | 6 | Error strobes, one per error type |
| err_addr_i | input | 32 | Address of the erring transaction |
| err_attr_i | input | 8 | Attributes of the erring transaction |
| err_data_i | input | 32 | Data of the erring transaction |
| ob_rdata_i | input | 32 | Outbound read data from the bus |
| ob_cfg_ma_i | input | 1 | Outbound configuration read ended in master abort |
| ob_rdata_o | output | 32 | Read data returned to the requester |
| irq_o | output | 1 | Level interrupt |

## Verification
Detect, enable and capture values are due at the edge that takes the strobe or write, and the bench reads them combinationally one step after that edge. `irq_o` is due one edge later than the detect or enable change that causes it, so the bench waits for a further edge before it samples the interrupt. The read-data override is combinational and is checked in the same cycle it is driven. All sampling happens away from the rising edge.

// File: rtl/bus_err_pkg.sv
package bus_err_pkg;
  typedef enum logic [2:0] {
    RA_DET   = 3'd0,
    RA_ENA   = 3'd1,
    RA_CATTR = 3'd2,
    RA_CADDR = 3'd3,
    RA_CDATA = 3'd4
  } reg_sel_e;

  localparam int REG_W          = 32;
  localparam int ERR_MA         = 0;
  localparam int ERR_PAR        = 1;
  localparam int CATTR_VALID    = 31;
  localparam int CATTR_TYPE_LSB = 16;
endpackage

// File: rtl/err_detect.sv
module err_detect #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] det_o
);
  logic [N-1:0] det_q, clr;

  assign clr = clr_we_i ? clr_mask_i : '0;

  // set applied after clear: simultaneous event wins
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) det_q <= '0;
    else         det_q <= (det_q & ~clr) | ev_i;

  assign det_o = det_q;

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> ((det_q & $past(ev_i)) == $past(ev_i)));

  a_r3_write_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == '0) |=> ((det_q & ~$past(det_q)) == '0));

  a_r3_unwritten_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i) |=> ((det_q & $past(det_q)) == $past(det_q)));
endmodule

// File: rtl/err_capture.sv
module err_capture #(
  parameter int N  = 6,
  parameter int AW = 32,
  parameter int TW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  ev_i,
  input  logic [N-1:0]  det_i,
  input  logic [AW-1:0] addr_i,
  input  logic [TW-1:0] attr_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [N-1:0]  type_o,
  output logic [AW-1:0] addr_o,
  output logic [TW-1:0] attr_o,
  output logic [DW-1:0] data_o
);
  logic          armed, take, valid_q;
  logic [N-1:0]  type_q;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] attr_q;
  logic [DW-1:0] data_q;

  assign armed = (det_i == '0);
  assign take  = armed && (|ev_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_q <= 1'b0;
      type_q  <= '0;
      addr_q  <= '0;
      attr_q  <= '0;
      data_q  <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      type_q  <= ev_i;
      addr_q  <= addr_i;
      attr_q  <= attr_i;
      data_q  <= data_i;
    end else if (armed) begin
      valid_q <= 1'b0;
    end

  // flag hidden once detect is clear, even before valid_q drops
  assign valid_o = valid_q & ~armed;
  assign type_o  = type_q;
  assign addr_o  = addr_q;
  assign attr_o  = attr_q;
  assign data_o  = data_q;

  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|det_i) |=> ($stable(addr_q) && $stable(data_q) && $stable(attr_q) && $stable(type_q)));

  a_r7_rearm_captures: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((det_i == '0) && (|ev_i)) |=> valid_q);
endmodule

// File: rtl/err_irq.sv
module err_irq #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] det_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(det_i & en_i);

  assign irq_o = irq_q;

  a_r5_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((det_i & en_i) == '0) |=> !irq_o);

  a_r11_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i == '0) |=> !irq_o);
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bus_err_pkg::*;
#(
  parameter int N_ERR  = 6,
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [N_ERR-1:0]  err_ev_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [ATTR_W-1:0] err_attr_i,
  input  logic [DATA_W-1:0] err_data_i,
  input  logic [DATA_W-1:0] ob_rdata_i,
  input  logic              ob_cfg_ma_i,
  output logic [DATA_W-1:0] ob_rdata_o,
  output logic              irq_o
);
  localparam int SEL_W = $bits(reg_sel_e);

  reg_sel_e          sel;
  logic [N_ERR-1:0]  det, ena_q, cap_type;
  logic              cap_valid;
  logic [ADDR_W-1:0] cap_addr;
  logic [ATTR_W-1:0] cap_attr;
  logic [DATA_W-1:0] cap_data;
  logic [REG_W-1:0]  cattr;

  assign sel = reg_sel_e'(reg_addr_i[SEL_W-1:0]);

  err_detect #(.N(N_ERR)) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (err_ev_i),
    .clr_we_i   (reg_we_i && sel == RA_DET),
    .clr_mask_i (reg_wdata_i[N_ERR-1:0]),
    .det_o      (det)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                      ena_q <= '0;
    else if (reg_we_i && sel == RA_ENA) ena_q <= reg_wdata_i[N_ERR-1:0];

  err_capture #(.N(N_ERR), .AW(ADDR_W), .TW(ATTR_W), .DW(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (err_ev_i),
    .det_i   (det),
    .addr_i  (err_addr_i),
    .attr_i  (err_attr_i),
    .data_i  (err_data_i),
    .valid_o (cap_valid),
    .type_o  (cap_type),
    .addr_o  (cap_addr),
    .attr_o  (cap_attr),
    .data_o  (cap_data)
  );

  err_irq #(.N(N_ERR)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .det_i  (det),
    .en_i   (ena_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    cattr = '0;
    cattr[CATTR_VALID] = cap_valid;
    cattr[CATTR_TYPE_LSB +: N_ERR] = cap_type;
    cattr[ATTR_W-1:0] = cap_attr;
  end

  always_comb
    unique case (sel)
      RA_DET:   reg_rdata_o = REG_W'(det);
      RA_ENA:   reg_rdata_o = REG_W'(ena_q);
      RA_CATTR: reg_rdata_o = cattr;
      RA_CADDR: reg_rdata_o = REG_W'(cap_addr);
      RA_CDATA: reg_rdata_o = REG_W'(cap_data);
      default:  reg_rdata_o = '0;
    endcase

  // aborted config read returns all-ones
  assign ob_rdata_o = ob_cfg_ma_i ? '1 : ob_rdata_i;

  a_r9_ma_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ob_cfg_ma_i |-> (&ob_rdata_o));

  a_r10_ma_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ena_q[ERR_MA] && (det & ena_q) == '0) |=> !irq_o);
endmodule

// File: tb/sim_bus_err_capture.sv
module sim_bus_err_capture;
  import bus_err_pkg::*;

  logic        clk = 0, rst_ni = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [5:0]  err_ev = 0;
  logic [31:0] err_addr = 0, err_data = 0;
  logic [7:0]  err_attr = 0;
  logic [31:0] ob_rdata_in = 0, ob_rdata_out;
  logic        ob_cfg_ma = 0, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_err_capture u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .err_ev_i(err_ev),
    .err_addr_i(err_addr), .err_attr_i(err_attr), .err_data_i(err_data),
    .ob_rdata_i(ob_rdata_in), .ob_cfg_ma_i(ob_cfg_ma), .ob_rdata_o(ob_rdata_out),
    .irq_o(irq)
  );

  // {ev[5:0], we, wdata[5:0], expected detect[5:0]}
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {6'b000001, 1'b0, 6'b000000, 6'b000001},
    {6'b000100, 1'b0, 6'b000000, 6'b000101},
    {6'b000000, 1'b1, 6'b000001, 6'b000100},
    {6'b000000, 1'b1, 6'b000000, 6'b000100},
    {6'b100000, 1'b1, 6'b100100, 6'b100000},
    {6'b011000, 1'b0, 6'b000000, 6'b111000},
    {6'b000000, 1'b1, 6'b101000, 6'b010000},
    {6'b000000, 1'b1, 6'b111111, 6'b000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then return to idle with detect selected
  task automatic step(input logic [5:0] ev, input logic we, input logic [2:0] ra,
                      input logic [31:0] wd, input logic [31:0] ea,
                      input logic [7:0] at, input logic [31:0] ed);
    @(negedge clk);
    err_ev = ev; reg_we = we; reg_addr = ra; reg_wdata = wd;
    err_addr = ea; err_attr = at; err_data = ed;
    @(posedge clk); #1;
    err_ev = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    #1;
  endtask

  task automatic rd(input logic [2:0] ra);
    reg_addr = ra; #1;
  endtask

  task automatic tick;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    rd(RA_DET);   chk("R1 detect", reg_rdata, 0);
    rd(RA_ENA);   chk("R1 enable", reg_rdata, 0);
    rd(RA_CATTR); chk("R1 cattr", reg_rdata, 0);
    rd(RA_CADDR); chk("R1 caddr", reg_rdata, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    @(negedge clk); rst_ni = 1;

    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18:13], VEC[i][12], RA_DET, {26'b0, VEC[i][11:6]}, 32'h0, 8'h0, 32'h0);
      chk("R2 R3 R4 table", reg_rdata, {26'b0, VEC[i][5:0]});
    end

    // R8 unused bits of enable read zero
    step(0, 1, RA_ENA, 32'hFFFF_FFFF, 0, 0, 0);
    rd(RA_ENA); chk("R8 enable width", reg_rdata, 32'h3F);
    step(0, 1, RA_ENA, 32'h0, 0, 0, 0);

    // R6 first error captured
    step(6'b000010, 0, RA_DET, 0, 32'hA000_1000, 8'h5A, 32'hD1D1_D1D1);
    rd(RA_CADDR); chk("R6 caddr", reg_rdata, 32'hA000_1000);
    rd(RA_CDATA); chk("R6 cdata", reg_rdata, 32'hD1D1_D1D1);
    rd(RA_CATTR); chk("R6 R7 cattr valid", reg_rdata, 32'h8002_005A);
    step(6'b000100, 0, RA_DET, 0, 32'hB000_2000, 8'h33, 32'hD2D2_D2D2);
    chk("R2 second error detect", reg_rdata, 32'h06);
    rd(RA_CADDR); chk("R6 caddr frozen", reg_rdata, 32'hA000_1000);
    rd(RA_CDATA); chk("R6 cdata frozen", reg_rdata, 32'hD1D1_D1D1);
    // R8 capture regs not writable
    step(0, 1, RA_CADDR, 32'h0, 0, 0, 0);
    rd(RA_CADDR); chk("R8 caddr write ignored", reg_rdata, 32'hA000_1000);
    step(0, 1, RA_CATTR, 32'h0, 0, 0, 0);
    rd(RA_CATTR); chk("R8 cattr write ignored", reg_rdata, 32'h8002_005A);

    // R5 detect recorded while disabled, no irq
    tick();
    chk("R5 irq masked", {31'b0, irq}, 0);
    // R7 clear all, valid drops, re-arm
    step(0, 1, RA_DET, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R11 detect cleared", reg_rdata, 0);
    rd(RA_CATTR); chk("R7 valid low", {31'b0, reg_rdata[31]}, 0);
    step(6'b001000, 0, RA_DET, 0, 32'hC000_3000, 8'h11, 32'hD3D3_D3D3);
    rd(RA_CADDR); chk("R7 recapture addr", reg_rdata, 32'hC000_3000);
    rd(RA_CATTR); chk("R7 recapture attr", reg_rdata, 32'h8008_0011);

    // R5 enable bit 3 raises irq one clock later
    step(0, 1, RA_ENA, 32'h08, 0, 0, 0);
    chk("R5 irq not yet", {31'b0, irq}, 0);
    tick();
    chk("R5 irq high", {31'b0, irq}, 1);
    // R11 clear all drops irq
    step(0, 1, RA_DET, 32'hFFFF_FFFF, 0, 0, 0);
    tick();
    chk("R11 irq low", {31'b0, irq}, 0);

    // R10 master abort masked, parity enabled
    step(0, 1, RA_ENA, 32'h02, 0, 0, 0);
    step(6'b000001, 0, RA_DET, 0, 0, 0, 0);
    chk("R10 ma recorded", reg_rdata, 32'h01);
    tick();
    chk("R10 ma no irq", {31'b0, irq}, 0);
    step(6'b000010, 0, RA_DET, 0, 0, 0, 0);
    tick();
    chk("R10 parity irq", {31'b0, irq}, 1);

    // R9 read data override
    @(negedge clk);
    ob_rdata_in = 32'h0000_1234; ob_cfg_ma = 1; #1;
    chk("R9 ma all ones", ob_rdata_out, 32'hFFFF_FFFF);
    ob_cfg_ma = 0; #1;
    chk("R9 passthrough", ob_rdata_out, 32'h0000_1234);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule